// File: doc/BRIEF.md
# Ethernet Pause Flow-Control Resolver

Once auto-negotiation has finished, this block settles which pause directions the MAC should honour. It takes four inputs:

- the local and link-partner advertisement bits (symmetric pause and asymmetric direction);
- the mode software requested;
- a strict-standard flag;
- the negotiated duplex.

From these it produces a 2-bit mode and the transmit and receive flow-control enables.

When auto-negotiation is disabled or has failed, the requested mode is applied as it stands. The advertisements are not consulted on that path.

A caller presents the inputs and pulses a start strobe. The result is registered and appears one cycle later, together with a single-cycle done pulse. When no standard resolution case matches, the block does not fall back to "no pause". It falls back to receive-only pause, unless the request rules pause out or strict mode is set.

Top module: `pause_fc_resolver`

## Requirements
- R1: Mode encoding on mode_o is 0 = none, 1 = receive-only, 2 = transmit-only, 3 = full. The enables follow it: rx_fc_en_o is set for modes 1 and 3, and tx_fc_en_o is set for modes 2 and 3.
- R2: Request codes 0 to 3 on req_mode_i carry the mode encoding of R1. Code 4 means "default" and is treated as full before any resolution. Codes 5 to 7 are invalid.
- R3: On the negotiated path, if both the local and partner symmetric-pause bits are set, the result is full when the effective request is full, and receive-only otherwise.
- R4: On the negotiated path, local pause 0 / asym 1 with partner pause 1 / asym 1 resolves to transmit-only.
- R5: On the negotiated path, local pause 1 / asym 1 with partner pause 0 / asym 1 resolves to receive-only.
- R6: On the negotiated path, when none of R3 to R5 applies, the result is none if the effective request is none or transmit-only, or if strict_i is set. Otherwise it is receive-only.
- R7: On the negotiated path, a half-duplex link (full_duplex_i = 0) forces the result to none, whatever the advertisement bits are.
- R8: When an_failed_i = 1 or an_enable_i = 0 (the forced path), the effective request is applied directly. Advertisement bits, strict_i and full_duplex_i are ignored.
- R9: On the negotiated path with an_complete_i = 0, a start leaves mode_o, the enables and cfg_err_o unchanged, and done_o still pulses.
- R10: An invalid request on a path that is not skipped sets cfg_err_o and leaves mode_o and the enables unchanged. Any resolution that loads a result clears cfg_err_o.
- R11: Outputs change only on the clock edge that samples start_i high. done_o is high for exactly the cycle after that edge.
- R12: After reset, mode_o = 0, both enables = 0, done_o = 0 and cfg_err_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Resolve strobe, one cycle |
| an_enable_i | input | 1 | Auto-negotiation is in use |
| an_failed_i | input | 1 | Auto-negotiation failed, link forced |
| an_complete_i | input | 1 | Auto-negotiation has completed |
| req_mode_i | input | REQ_W | Requested mode code |
| strict_i | input | 1 | Follow the standard exactly, no receive-only fallback |
| full_duplex_i | input | 1 | Negotiated link is full duplex |
| loc_pause_i | input | 1 | Local symmetric-pause advertisement |
| loc_asm_dir_i | input | 1 | Local asymmetric-direction advertisement |
| lp_pause_i | input | 1 | Partner symmetric-pause advertisement |
| lp_asm_dir_i | input | 1 | Partner asymmetric-direction advertisement |
| mode_o | output | 2 | Resolved mode |
| tx_fc_en_o | output | 1 | Transmit pause enable |
| rx_fc_en_o | output | 1 | Receive pause enable |
| done_o | output | 1 | Result valid, one-cycle pulse |
| cfg_err_o | output | 1 | Last request was invalid |

## Verification
A wrong path select, such as a forced request going through the negotiation table, or a dropped half-duplex override, shows up as a wrong mode_o in the first cycle after the start strobe. The held state is also exercised. After a skipped or invalid start, the previous result has to remain at the ports, so a stale or overwritten register is visible on the very next done pulse. During the cycle after it the inputs are perturbed with start low, and any change at the outputs in that cycle exposes an enable that is not properly gated.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_RX   = 2'd1,
    FC_TX   = 2'd2,
    FC_FULL = 2'd3
  } fc_mode_e;
endpackage

// File: rtl/fcr_req_decode.sv
module fcr_req_decode
  import fcr_pkg::*;
#(
  parameter int unsigned REQ_W        = 3,
  parameter int unsigned DEFAULT_CODE = 4
) (
  input  logic [REQ_W-1:0] req_i,
  output fc_mode_e         mode_o,
  output logic             valid_o
);
  localparam logic [REQ_W-1:0] DefCode = REQ_W'(DEFAULT_CODE);

  generate
    if (REQ_W > 2) begin : g_wide
      logic in_range, is_def;
      assign in_range = ~|req_i[REQ_W-1:2];
      assign is_def   = (req_i == DefCode);
      assign valid_o  = in_range | is_def;
      assign mode_o   = is_def ? FC_FULL : fc_mode_e'(req_i[1:0]);
    end else begin : g_narrow
      assign valid_o = 1'b1;
      assign mode_o  = fc_mode_e'(req_i[1:0]);
    end
  endgenerate
endmodule

// File: rtl/fcr_pause_resolve.sv
module fcr_pause_resolve
  import fcr_pkg::*;
(
  input  fc_mode_e req_i,
  input  logic     strict_i,
  input  logic     full_duplex_i,
  input  logic     loc_pause_i,
  input  logic     loc_asm_i,
  input  logic     lp_pause_i,
  input  logic     lp_asm_i,
  output fc_mode_e mode_o
);
  fc_mode_e adv_mode;

  always_comb begin
    if (loc_pause_i && lp_pause_i)
      adv_mode = (req_i == FC_FULL) ? FC_FULL : FC_RX;
    else if (!loc_pause_i && loc_asm_i && lp_pause_i && lp_asm_i)
      adv_mode = FC_TX;
    else if (loc_pause_i && loc_asm_i && !lp_pause_i && lp_asm_i)
      adv_mode = FC_RX;
    else if (req_i == FC_NONE || req_i == FC_TX || strict_i)
      adv_mode = FC_NONE;
    else
      adv_mode = FC_RX; // lenient fallback: accept pause frames
  end

  assign mode_o = full_duplex_i ? adv_mode : FC_NONE;
endmodule

// File: rtl/fcr_out_reg.sv
module fcr_out_reg
  import fcr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       load_i,
  input  logic       err_i,
  input  fc_mode_e   mode_i,
  output logic [1:0] mode_o,
  output logic       tx_en_o,
  output logic       rx_en_o,
  output logic       done_o,
  output logic       cfg_err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o    <= 2'd0;
      tx_en_o   <= 1'b0;
      rx_en_o   <= 1'b0;
      done_o    <= 1'b0;
      cfg_err_o <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i && load_i) begin
        mode_o    <= mode_i;
        tx_en_o   <= (mode_i == FC_TX) || (mode_i == FC_FULL);
        rx_en_o   <= (mode_i == FC_RX) || (mode_i == FC_FULL);
        cfg_err_o <= 1'b0;
      end else if (start_i && err_i) begin
        cfg_err_o <= 1'b1;
      end
    end
  end

  a_r1_enable_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o == mode_o[1]) && (rx_en_o == mode_o[0]));

  a_r11_done_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i));

  a_r11_hold_without_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(mode_o) && $stable(cfg_err_o) && !done_o));

  a_r10_err_keeps_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && err_i && !load_i) |=> (cfg_err_o && $stable(mode_o)));
endmodule

// File: rtl/pause_fc_resolver.sv
module pause_fc_resolver
  import fcr_pkg::*;
#(
  parameter int unsigned REQ_W        = 3,
  parameter int unsigned DEFAULT_CODE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             an_enable_i,
  input  logic             an_failed_i,
  input  logic             an_complete_i,
  input  logic [REQ_W-1:0] req_mode_i,
  input  logic             strict_i,
  input  logic             full_duplex_i,
  input  logic             loc_pause_i,
  input  logic             loc_asm_dir_i,
  input  logic             lp_pause_i,
  input  logic             lp_asm_dir_i,
  output logic [1:0]       mode_o,
  output logic             tx_fc_en_o,
  output logic             rx_fc_en_o,
  output logic             done_o,
  output logic             cfg_err_o
);
  fc_mode_e req_mode, neg_mode, next_mode;
  logic     req_valid, forced, skip, load, err;

  fcr_req_decode #(.REQ_W(REQ_W), .DEFAULT_CODE(DEFAULT_CODE)) u_dec (
    .req_i   (req_mode_i),
    .mode_o  (req_mode),
    .valid_o (req_valid)
  );

  fcr_pause_resolve u_res (
    .req_i         (req_mode),
    .strict_i      (strict_i),
    .full_duplex_i (full_duplex_i),
    .loc_pause_i   (loc_pause_i),
    .loc_asm_i     (loc_asm_dir_i),
    .lp_pause_i    (lp_pause_i),
    .lp_asm_i      (lp_asm_dir_i),
    .mode_o        (neg_mode)
  );

  assign forced    = an_failed_i | ~an_enable_i;
  assign skip      = ~forced & ~an_complete_i;
  assign next_mode = forced ? req_mode : neg_mode;
  assign load      = ~skip & req_valid;
  assign err       = ~skip & ~req_valid;

  fcr_out_reg u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .load_i    (load),
    .err_i     (err),
    .mode_i    (next_mode),
    .mode_o    (mode_o),
    .tx_en_o   (tx_fc_en_o),
    .rx_en_o   (rx_fc_en_o),
    .done_o    (done_o),
    .cfg_err_o (cfg_err_o)
  );

  a_r7_half_duplex_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !forced && an_complete_i && req_valid && !full_duplex_i)
      |=> (mode_o == 2'd0 && !tx_fc_en_o && !rx_fc_en_o));

  a_r9_skip_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && skip) |=> ($stable(mode_o) && $stable(cfg_err_o) && done_o));

  a_r8_forced_applies_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && forced && req_valid) |=> (mode_o == $past(req_mode)));
endmodule

// File: tb/pause_fc_resolver_bench.sv
module pause_fc_resolver_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, an_en = 1'b0, an_fail = 1'b0, an_done = 1'b0;
  logic [2:0] req = 3'd0;
  logic       strict = 1'b0, fdx = 1'b0;
  logic [3:0] adv = 4'd0; // {loc_pause, loc_asm, lp_pause, lp_asm}
  logic [1:0] mode;
  logic       tx_en, rx_en, done, cfg_err;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [1:0] exp_mode = 2'd0;
  logic       exp_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pause_fc_resolver u_pause_fc_resolver (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start),
    .an_enable_i (an_en), .an_failed_i (an_fail), .an_complete_i (an_done),
    .req_mode_i (req), .strict_i (strict), .full_duplex_i (fdx),
    .loc_pause_i (adv[3]), .loc_asm_dir_i (adv[2]),
    .lp_pause_i (adv[1]), .lp_asm_dir_i (adv[0]),
    .mode_o (mode), .tx_fc_en_o (tx_en), .rx_fc_en_o (rx_en),
    .done_o (done), .cfg_err_o (cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // bench model built from the requirements
  task automatic predict(output string tag);
    int eff;
    bit valid, frc;
    eff   = (req == 3'd4) ? 3 : int'(req);
    valid = (req <= 3'd4);
    frc   = an_fail || !an_en;
    if (!frc && !an_done) begin
      tag = "R9";
    end else if (!valid) begin
      tag = "R10"; exp_err = 1'b1;
    end else begin
      exp_err = 1'b0;
      if (frc) begin
        tag = (req == 3'd4) ? "R2" : "R8";
        exp_mode = 2'(eff);
      end else if (!fdx) begin
        tag = "R7"; exp_mode = 2'd0;
      end else if (adv[3] && adv[1]) begin
        tag = "R3"; exp_mode = (eff == 3) ? 2'd3 : 2'd1;
      end else if (adv == 4'b0111) begin
        tag = "R4"; exp_mode = 2'd2;
      end else if (adv == 4'b1101) begin
        tag = "R5"; exp_mode = 2'd1;
      end else begin
        tag = "R6";
        exp_mode = (eff == 0 || eff == 2 || strict) ? 2'd0 : 2'd1;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    chk(mode == 2'd0 && !tx_en && !rx_en && !done && !cfg_err, "R12 reset",
        int'({mode, tx_en, rx_en, done, cfg_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mode == 2'd0 && !done, "R12 after release", int'({mode, done}), 0);

    for (int i = 0; i < 4096; i++) begin
      @(negedge clk);
      req     = 3'(i);
      adv     = 4'(i >> 3);
      strict  = i[7];
      fdx     = i[8];
      an_done = i[9];
      an_fail = i[10];
      an_en   = i[11];
      start   = 1'b1;
      predict(tag);
      @(negedge clk);
      start = 1'b0;
      chk(mode == exp_mode, {tag, " mode"}, int'(mode), int'(exp_mode));
      chk(cfg_err == exp_err, {tag, " cfg_err"}, int'(cfg_err), int'(exp_err));
      chk(tx_en == exp_mode[1] && rx_en == exp_mode[0], "R1 enables",
          int'({tx_en, rx_en}), int'(exp_mode));
      chk(done == 1'b1, "R11 done pulse", int'(done), 1);
      // perturb everything with start low: nothing may move
      req = ~req; adv = ~adv; strict = ~strict; fdx = ~fdx;
      an_done = ~an_done; an_fail = ~an_fail; an_en = ~an_en;
      @(negedge clk);
      chk(done == 1'b0, "R11 done width", int'(done), 0);
      chk(mode == exp_mode && cfg_err == exp_err, "R11 hold without start",
          int'({mode, cfg_err}), int'({exp_mode, exp_err}));
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule